// File: doc/BRIEF.md
# Synchronous Exception Dispatch Unit

This block receives one synchronous exception request at a time from a processor pipeline and updates the exception special registers in a single step. A request carries a kind code, the faulting program counter, a cause code, an instruction-side fault address, a data-side fault address and the current processor-status fields (user mode, exception mode, interrupt level). From these the unit picks a vector (user, kernel, double or debug). It records the program counter, cause and fault address in the matching holding registers and produces the next processor-status value.

General exceptions record a cause. A nested exception, raised while exception mode is already set, is routed to the double vector, and its program counter goes to a separate double-exception register when that register is configured. The debug path is taken only below a configurable debug interrupt level. It saves the old status into a status-save register for that level, the program counter into a program-counter register for that level, and raises the interrupt level. All register updates and a one-cycle vector-valid pulse appear together.

A two-state controller sequences each request. In state IDLE the unit is ready. Transition IDLE→SIGNAL happens when a valid request is accepted, meaning it is ready, valid and effective. State SIGNAL asserts the vector pulse and is not ready. Transition SIGNAL→IDLE is unconditional after one cycle. A valid request that has no effect leaves the controller in IDLE.

Top module: `exc_dispatch`

## Requirements
- R1: After reset, status out has exception mode 1, interrupt level 15 (all ones), user mode 0. Vector-valid is 0, request-ready is 1, and every holding register reads 0.
- R2: A general exception with input exception mode 0 writes the program counter to `epc1`. The vector code is 0 (user) when input user mode is 1 and 1 (kernel) when it is 0.
- R3: A general exception with input exception mode 1 gives vector code 2 (double). With the double register configured (the default), the program counter goes to `depc` and `epc1` is unchanged.
- R4: Every general exception writes its effective cause to `excause` and drives status out to exception mode 1, with user mode and interrupt level copied from the inputs.
- R5: Kind 0 (plain) records `req_cause` and leaves `excvaddr` unchanged. Kind 1 (address fault) records `req_cause` and loads `excvaddr` with `req_daddr`.
- R6: Kind 2 (fetch bus error) records cause 12 and loads `excvaddr` from `req_faddr`. Kind 3 (data bus error) records cause 13 and loads `excvaddr` from `req_daddr`.
- R7: Kind 4 (misaligned) records cause 9 and loads `excvaddr` from `req_daddr` only when unaligned trapping is enabled and hardware alignment handling is absent. Otherwise the request produces no pulse and no register change.
- R8: Kind 5 (debug) is taken only when the input interrupt level is below the debug level (default 6). At or above it, the request produces no pulse and no register change.
- R9: A taken debug request gives vector code 3. It writes `req_cause[5:0]` to `debugcause`, the program counter to `epc_dbg`, and the old status packed as {user, exception, level[3:0]} to `eps_dbg`. Status out gets interrupt level equal to the debug level and exception mode 1, with user mode kept. `excause` and `epc1` are unchanged.
- R10: An accepted request's register updates and the vector-valid pulse appear together after the accepting clock edge. The pulse lasts exactly one cycle, and request-ready is 0 during it, so a request presented then is ignored.
- R11: Kind codes 6 and 7 are ignored: no pulse and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Exception request present |
| req_ready | output | 1 | Unit can accept a request |
| req_kind | input | 3 | Request kind code |
| req_pc | input | 32 | Faulting program counter |
| req_cause | input | 6 | Cause code (general or debug) |
| req_faddr | input | 32 | Instruction-side fault address |
| req_daddr | input | 32 | Data-side fault address |
| ps_in_um | input | 1 | Current user-mode bit |
| ps_in_excm | input | 1 | Current exception-mode bit |
| ps_in_intlevel | input | 4 | Current interrupt level |
| vec_valid | output | 1 | One-cycle vector pulse |
| vec_sel | output | 2 | Selected vector code |
| ps_out_um | output | 1 | New user-mode bit |
| ps_out_excm | output | 1 | New exception-mode bit |
| ps_out_intlevel | output | 4 | New interrupt level |
| epc1 | output | 32 | First-level saved program counter |
| depc | output | 32 | Double-exception saved program counter |
| excause | output | 6 | Recorded exception cause |
| excvaddr | output | 32 | Recorded fault address |
| debugcause | output | 6 | Recorded debug cause |
| epc_dbg | output | 32 | Saved program counter at debug level |
| eps_dbg | output | 6 | Saved status at debug level |

## Verification
Each request is driven on a falling edge and accepted at the next rising edge. Every result (the vector pulse, vector code, status out and all holding registers) is due one cycle after that stimulus and is sampled at the following falling edge. The bench checks again one cycle later that the pulse has dropped. For ignored requests (disabled misalignment, debug at or above the level, unused kinds) the same sampling points must show no pulse and unchanged registers. A request placed in the pulse cycle is checked the same way.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
    localparam int PS_IL_W = 4;
    localparam int KIND_W  = 3;

    localparam logic [KIND_W-1:0] KIND_GEN       = 3'd0;
    localparam logic [KIND_W-1:0] KIND_GEN_VA    = 3'd1;
    localparam logic [KIND_W-1:0] KIND_FETCH_BUS = 3'd2;
    localparam logic [KIND_W-1:0] KIND_DATA_BUS  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_MISALIGN  = 3'd4;
    localparam logic [KIND_W-1:0] KIND_DEBUG     = 3'd5;

    typedef enum logic [1:0] {
        VEC_USER   = 2'd0,
        VEC_KERNEL = 2'd1,
        VEC_DOUBLE = 2'd2,
        VEC_DEBUG  = 2'd3
    } exc_vec_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_SIGNAL = 1'b1
    } disp_state_e;

    typedef struct packed {
        logic               um;
        logic               excm;
        logic [PS_IL_W-1:0] intlevel;
    } ps_t;
endpackage

// File: rtl/exc_classify.sv
`timescale 1ns/1ps
module exc_classify
    import exc_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int CAUSE_W       = 6,
    parameter int ALIGN_CAUSE   = 9,
    parameter int FETCH_CAUSE   = 12,
    parameter int DATA_CAUSE    = 13,
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0,
    parameter int DEBUG_LEVEL   = 6
) (
    input  logic [KIND_W-1:0]  kind,
    input  logic [CAUSE_W-1:0] cause_in,
    input  logic [ADDR_W-1:0]  faddr,
    input  logic [ADDR_W-1:0]  daddr,
    input  logic [PS_IL_W-1:0] cur_level,
    output logic               take_gen,
    output logic               take_dbg,
    output logic [CAUSE_W-1:0] eff_cause,
    output logic               load_va,
    output logic [ADDR_W-1:0]  eff_va
);
    localparam logic [PS_IL_W-1:0] DBG_LVL = PS_IL_W'(DEBUG_LEVEL);
    localparam logic [CAUSE_W-1:0] C_ALIGN = CAUSE_W'(ALIGN_CAUSE);
    localparam logic [CAUSE_W-1:0] C_FETCH = CAUSE_W'(FETCH_CAUSE);
    localparam logic [CAUSE_W-1:0] C_DATA  = CAUSE_W'(DATA_CAUSE);

    logic align_trap;

    generate
        if (UNALIGNED_EXC && !HW_ALIGN) begin : g_align_on
            assign align_trap = 1'b1;
        end else begin : g_align_off
            assign align_trap = 1'b0;
        end
    endgenerate

    always_comb begin
        take_gen  = 1'b0;
        take_dbg  = 1'b0;
        eff_cause = cause_in;
        load_va   = 1'b0;
        eff_va    = daddr;
        case (kind)
            KIND_GEN: begin
                take_gen = 1'b1;
            end
            KIND_GEN_VA: begin
                take_gen = 1'b1;
                load_va  = 1'b1;
            end
            KIND_FETCH_BUS: begin
                take_gen  = 1'b1;
                eff_cause = C_FETCH;
                load_va   = 1'b1;
                eff_va    = faddr;
            end
            KIND_DATA_BUS: begin
                take_gen  = 1'b1;
                eff_cause = C_DATA;
                load_va   = 1'b1;
            end
            KIND_MISALIGN: begin
                take_gen  = align_trap;
                eff_cause = C_ALIGN;
                load_va   = align_trap;
            end
            KIND_DEBUG: begin
                take_dbg = (cur_level < DBG_LVL);
            end
            default: begin
                take_gen = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/exc_route.sv
`timescale 1ns/1ps
module exc_route
    import exc_pkg::*;
#(
    parameter bit HAS_DEPC    = 1'b1,
    parameter int DEBUG_LEVEL = 6
) (
    input  ps_t      ps_cur,
    input  logic     take_dbg,
    output exc_vec_e vec,
    output ps_t      ps_next,
    output logic     to_depc,
    output logic     to_epc1
);
    localparam logic [PS_IL_W-1:0] DBG_LVL = PS_IL_W'(DEBUG_LEVEL);
    localparam logic               DEPC_ON = HAS_DEPC;

    always_comb begin
        ps_next      = ps_cur;
        ps_next.excm = 1'b1;
        to_depc      = 1'b0;
        to_epc1      = 1'b0;
        if (take_dbg) begin
            vec              = VEC_DEBUG;
            ps_next.intlevel = DBG_LVL;
        end else if (ps_cur.excm) begin
            vec     = VEC_DOUBLE;
            to_depc = DEPC_ON;
            to_epc1 = !DEPC_ON;
        end else begin
            vec     = ps_cur.um ? VEC_USER : VEC_KERNEL;
            to_epc1 = 1'b1;
        end
    end
endmodule

// File: rtl/exc_dispatch_fsm.sv
`timescale 1ns/1ps
module exc_dispatch_fsm
    import exc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic take,
    output logic req_ready,
    output logic accept,
    output logic vec_valid
);
    disp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid && take) state_d = ST_SIGNAL;
            ST_SIGNAL: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        vec_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_SIGNAL: vec_valid = 1'b1;
        endcase
        accept = req_ready && req_valid && take;
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid); // R10
    AST_ACCEPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> vec_valid); // R10
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> !req_ready); // R10
endmodule

// File: rtl/exc_sreg_file.sv
`timescale 1ns/1ps
module exc_sreg_file
    import exc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CAUSE_W     = 6,
    parameter int DBG_CAUSE_W = 6,
    parameter bit HAS_DEPC    = 1'b1,
    parameter int DEBUG_LEVEL = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   accept,
    input  logic                   take_gen,
    input  logic                   take_dbg,
    input  logic                   load_va,
    input  logic                   to_depc,
    input  logic                   to_epc1,
    input  logic [ADDR_W-1:0]      pc,
    input  logic [CAUSE_W-1:0]     cause,
    input  logic [ADDR_W-1:0]      va,
    input  ps_t                    ps_cur,
    input  ps_t                    ps_next,
    input  exc_vec_e               vec,
    output ps_t                    ps_q,
    output exc_vec_e               vec_q,
    output logic [ADDR_W-1:0]      epc1_q,
    output logic [ADDR_W-1:0]      depc_q,
    output logic [CAUSE_W-1:0]     excause_q,
    output logic [ADDR_W-1:0]      excvaddr_q,
    output logic [DBG_CAUSE_W-1:0] dbgcause_q,
    output logic [ADDR_W-1:0]      epc_dbg_q,
    output ps_t                    eps_dbg_q
);
    localparam logic [PS_IL_W-1:0] IL_MAX  = '1;
    localparam logic [PS_IL_W-1:0] DBG_LVL = PS_IL_W'(DEBUG_LEVEL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q       <= '{um: 1'b0, excm: 1'b1, intlevel: IL_MAX};
            vec_q      <= VEC_USER;
            epc1_q     <= '0;
            excause_q  <= '0;
            excvaddr_q <= '0;
            dbgcause_q <= '0;
            epc_dbg_q  <= '0;
            eps_dbg_q  <= '0;
        end else if (accept) begin
            ps_q  <= ps_next;
            vec_q <= vec;
            if (take_gen) begin
                excause_q <= cause;
                if (load_va) excvaddr_q <= va;
                if (to_epc1) epc1_q <= pc;
            end
            if (take_dbg) begin
                dbgcause_q <= cause[DBG_CAUSE_W-1:0];
                epc_dbg_q  <= pc;
                eps_dbg_q  <= ps_cur;
            end
        end
    end

    generate
        if (HAS_DEPC) begin : g_depc
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                           depc_q <= '0;
                else if (accept && take_gen && to_depc) depc_q <= pc;
            end
        end else begin : g_no_depc
            assign depc_q = '0;
        end
    endgenerate

    AST_EXCM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ps_q.excm); // R4
    AST_DBG_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && take_dbg) |=> (ps_q.intlevel == DBG_LVL)); // R9
    AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && take_gen) |=> $stable(excause_q)); // R4
endmodule

// File: rtl/exc_dispatch.sv
`timescale 1ns/1ps
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int CAUSE_W       = 6,
    parameter int DBG_CAUSE_W   = 6,
    parameter int ALIGN_CAUSE   = 9,
    parameter int FETCH_CAUSE   = 12,
    parameter int DATA_CAUSE    = 13,
    parameter bit UNALIGNED_EXC = 1'b1,
    parameter bit HW_ALIGN      = 1'b0,
    parameter bit HAS_DEPC      = 1'b1,
    parameter int DEBUG_LEVEL   = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [2:0]             req_kind,
    input  logic [ADDR_W-1:0]      req_pc,
    input  logic [CAUSE_W-1:0]     req_cause,
    input  logic [ADDR_W-1:0]      req_faddr,
    input  logic [ADDR_W-1:0]      req_daddr,
    input  logic                   ps_in_um,
    input  logic                   ps_in_excm,
    input  logic [3:0]             ps_in_intlevel,
    output logic                   vec_valid,
    output logic [1:0]             vec_sel,
    output logic                   ps_out_um,
    output logic                   ps_out_excm,
    output logic [3:0]             ps_out_intlevel,
    output logic [ADDR_W-1:0]      epc1,
    output logic [ADDR_W-1:0]      depc,
    output logic [CAUSE_W-1:0]     excause,
    output logic [ADDR_W-1:0]      excvaddr,
    output logic [DBG_CAUSE_W-1:0] debugcause,
    output logic [ADDR_W-1:0]      epc_dbg,
    output logic [5:0]             eps_dbg
);
    localparam logic [PS_IL_W-1:0] DBG_LVL = PS_IL_W'(DEBUG_LEVEL);

    ps_t                ps_cur, ps_next, ps_q, eps_q;
    logic               take_gen, take_dbg, load_va, to_depc, to_epc1, accept;
    logic [CAUSE_W-1:0] eff_cause;
    logic [ADDR_W-1:0]  eff_va;
    exc_vec_e           vec_d, vec_q;

    assign ps_cur = '{um: ps_in_um, excm: ps_in_excm, intlevel: ps_in_intlevel};

    exc_classify #(
        .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .ALIGN_CAUSE(ALIGN_CAUSE),
        .FETCH_CAUSE(FETCH_CAUSE), .DATA_CAUSE(DATA_CAUSE),
        .UNALIGNED_EXC(UNALIGNED_EXC), .HW_ALIGN(HW_ALIGN),
        .DEBUG_LEVEL(DEBUG_LEVEL)
    ) u_classify (
        .kind(req_kind), .cause_in(req_cause), .faddr(req_faddr),
        .daddr(req_daddr), .cur_level(ps_in_intlevel),
        .take_gen(take_gen), .take_dbg(take_dbg), .eff_cause(eff_cause),
        .load_va(load_va), .eff_va(eff_va)
    );

    exc_route #(.HAS_DEPC(HAS_DEPC), .DEBUG_LEVEL(DEBUG_LEVEL)) u_route (
        .ps_cur(ps_cur), .take_dbg(take_dbg), .vec(vec_d),
        .ps_next(ps_next), .to_depc(to_depc), .to_epc1(to_epc1)
    );

    exc_dispatch_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .take(take_gen || take_dbg), .req_ready(req_ready),
        .accept(accept), .vec_valid(vec_valid)
    );

    exc_sreg_file #(
        .ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .DBG_CAUSE_W(DBG_CAUSE_W),
        .HAS_DEPC(HAS_DEPC), .DEBUG_LEVEL(DEBUG_LEVEL)
    ) u_sregs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .take_gen(take_gen),
        .take_dbg(take_dbg), .load_va(load_va), .to_depc(to_depc),
        .to_epc1(to_epc1), .pc(req_pc), .cause(eff_cause), .va(eff_va),
        .ps_cur(ps_cur), .ps_next(ps_next), .vec(vec_d), .ps_q(ps_q),
        .vec_q(vec_q), .epc1_q(epc1), .depc_q(depc), .excause_q(excause),
        .excvaddr_q(excvaddr), .dbgcause_q(debugcause), .epc_dbg_q(epc_dbg),
        .eps_dbg_q(eps_q)
    );

    assign vec_sel         = vec_q;
    assign ps_out_um       = ps_q.um;
    assign ps_out_excm     = ps_q.excm;
    assign ps_out_intlevel = ps_q.intlevel;
    assign eps_dbg         = eps_q;

    AST_NESTED_DOUBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && ps_in_excm && req_kind == KIND_GEN)
        |=> (vec_valid && vec_sel == VEC_DOUBLE)); // R3
    AST_DBG_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == KIND_DEBUG && ps_in_intlevel >= DBG_LVL)
        |=> !vec_valid); // R8
    AST_UNUSED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind > KIND_DEBUG) |=> !vec_valid); // R11
endmodule

// File: tb/exc_dispatch_bench.sv
`timescale 1ns/1ps
module exc_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_kind = '0;
    logic [31:0] req_pc = '0, req_faddr = '0, req_daddr = '0;
    logic [5:0]  req_cause = '0;
    logic        ps_in_um = 1'b0, ps_in_excm = 1'b0;
    logic [3:0]  ps_in_intlevel = '0;

    logic        req_ready, vec_valid, ps_out_um, ps_out_excm;
    logic [1:0]  vec_sel;
    logic [3:0]  ps_out_intlevel;
    logic [31:0] epc1, depc, excvaddr, epc_dbg;
    logic [5:0]  excause, debugcause, eps_dbg;

    logic        h_ready, h_valid, h_um, h_excm;
    logic [1:0]  h_vec;
    logic [3:0]  h_il;
    logic [31:0] h_epc1, h_depc, h_va, h_epcd;
    logic [5:0]  h_cause, h_dc, h_eps;

    always #2.5 clk = ~clk;

    exc_dispatch u_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_pc(req_pc), .req_cause(req_cause),
        .req_faddr(req_faddr), .req_daddr(req_daddr), .ps_in_um(ps_in_um),
        .ps_in_excm(ps_in_excm), .ps_in_intlevel(ps_in_intlevel),
        .vec_valid(vec_valid), .vec_sel(vec_sel), .ps_out_um(ps_out_um),
        .ps_out_excm(ps_out_excm), .ps_out_intlevel(ps_out_intlevel),
        .epc1(epc1), .depc(depc), .excause(excause), .excvaddr(excvaddr),
        .debugcause(debugcause), .epc_dbg(epc_dbg), .eps_dbg(eps_dbg)
    );

    exc_dispatch #(.HW_ALIGN(1'b1)) u_exc_dispatch_hwal (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(h_ready),
        .req_kind(req_kind), .req_pc(req_pc), .req_cause(req_cause),
        .req_faddr(req_faddr), .req_daddr(req_daddr), .ps_in_um(ps_in_um),
        .ps_in_excm(ps_in_excm), .ps_in_intlevel(ps_in_intlevel),
        .vec_valid(h_valid), .vec_sel(h_vec), .ps_out_um(h_um),
        .ps_out_excm(h_excm), .ps_out_intlevel(h_il),
        .epc1(h_epc1), .depc(h_depc), .excause(h_cause), .excvaddr(h_va),
        .debugcause(h_dc), .epc_dbg(h_epcd), .eps_dbg(h_eps)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // bench model of the holding registers
    logic [31:0] m_epc1 = '0, m_depc = '0, m_va = '0, m_epcd = '0;
    logic [5:0]  m_cause = '0, m_dc = '0, m_eps = '0;
    logic        m_um = 1'b0, m_excm = 1'b1;
    logic [3:0]  m_il = 4'hF;
    logic [1:0]  m_vec = '0;
    logic        m_valid = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] k, input logic ex);
        case (k)
            3'd0: return ex ? "R3" : "R2";
            3'd1: return "R5";
            3'd2, 3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R9";
            default: return "R11";
        endcase
    endfunction

    task automatic model(input logic [2:0] k);
        bit tg, td;
        logic [5:0] c;
        tg = (k <= 3'd4);
        td = (k == 3'd5) && (ps_in_intlevel < 4'd6);
        m_valid = tg || td;
        c = (k == 3'd2) ? 6'd12 : (k == 3'd3) ? 6'd13 : (k == 3'd4) ? 6'd9 : req_cause;
        if (tg) begin
            m_cause = c;
            if (k == 3'd1 || k == 3'd3 || k == 3'd4) m_va = req_daddr;
            if (k == 3'd2) m_va = req_faddr;
            if (ps_in_excm) begin m_vec = 2'd2; m_depc = req_pc; end
            else begin m_vec = ps_in_um ? 2'd0 : 2'd1; m_epc1 = req_pc; end
            m_um = ps_in_um; m_excm = 1'b1; m_il = ps_in_intlevel;
        end else if (td) begin
            m_dc = req_cause; m_epcd = req_pc;
            m_eps = {ps_in_um, ps_in_excm, ps_in_intlevel};
            m_vec = 2'd3; m_um = ps_in_um; m_excm = 1'b1; m_il = 4'd6;
        end
    endtask

    task automatic compare(input string r);
        chk(vec_valid == m_valid, r, "vec_valid", 64'(vec_valid), 64'(m_valid));
        if (m_valid) chk(vec_sel == m_vec, r, "vec_sel", 64'(vec_sel), 64'(m_vec));
        chk({ps_out_um, ps_out_excm, ps_out_intlevel} == {m_um, m_excm, m_il}, r, "ps_out",
            64'({ps_out_um, ps_out_excm, ps_out_intlevel}), 64'({m_um, m_excm, m_il}));
        chk(epc1 == m_epc1, r, "epc1", 64'(epc1), 64'(m_epc1));
        chk(depc == m_depc, r, "depc", 64'(depc), 64'(m_depc));
        chk(excause == m_cause, r, "excause", 64'(excause), 64'(m_cause));
        chk(excvaddr == m_va, r, "excvaddr", 64'(excvaddr), 64'(m_va));
        chk(debugcause == m_dc, r, "debugcause", 64'(debugcause), 64'(m_dc));
        chk(epc_dbg == m_epcd, r, "epc_dbg", 64'(epc_dbg), 64'(m_epcd));
        chk(eps_dbg == m_eps, r, "eps_dbg", 64'(eps_dbg), 64'(m_eps));
    endtask

    logic        h_seen;
    logic [5:0]  h_cause_before;

    task automatic apply(input logic [2:0] k, input logic [31:0] pc, input logic [5:0] c,
                         input logic [31:0] fa, input logic [31:0] da,
                         input logic um, input logic ex, input logic [3:0] il);
        @(negedge clk);
        req_kind = k; req_pc = pc; req_cause = c; req_faddr = fa; req_daddr = da;
        ps_in_um = um; ps_in_excm = ex; ps_in_intlevel = il;
        h_cause_before = h_cause;
        model(k);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        h_seen = h_valid;
        compare(req_of(k, ex));
        // R10: pulse lasts one cycle
        @(negedge clk);
        chk(!vec_valid, "R10", "pulse width", 64'(vec_valid), 64'd0);
        m_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(ps_out_excm == 1'b1 && ps_out_intlevel == 4'hF && ps_out_um == 1'b0, "R1", "ps reset",
            64'({ps_out_um, ps_out_excm, ps_out_intlevel}), 64'h1F);
        chk(!vec_valid && req_ready, "R1", "ready/valid", 64'({req_ready, vec_valid}), 64'h2);
        chk(epc1 == 0 && depc == 0 && excause == 0 && excvaddr == 0 && debugcause == 0
            && epc_dbg == 0 && eps_dbg == 0, "R1", "regs zero", 64'(excause), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: kernel and user vectors
        apply(3'd0, 32'h0000_1000, 6'd3, 32'h0, 32'h0, 1'b0, 1'b0, 4'd0);
        apply(3'd0, 32'h0000_2000, 6'd4, 32'h0, 32'h0, 1'b1, 1'b0, 4'd2);
        // R3: nested goes to double, depc
        apply(3'd0, 32'h0000_3000, 6'd5, 32'h0, 32'h0, 1'b0, 1'b1, 4'd1);
        // R5: address fault loads excvaddr, plain does not
        apply(3'd1, 32'h0000_4000, 6'd28, 32'h1111, 32'hABCD_0004, 1'b0, 1'b0, 4'd0);
        apply(3'd0, 32'h0000_4100, 6'd7, 32'h2222, 32'h5555_0000, 1'b0, 1'b0, 4'd0);
        // R6: bus errors
        apply(3'd2, 32'h0000_5000, 6'd1, 32'hF00D_0000, 32'hBEEF_0000, 1'b0, 1'b0, 4'd0);
        apply(3'd3, 32'h0000_5100, 6'd1, 32'hF00D_0000, 32'hBEEF_0008, 1'b1, 1'b0, 4'd3);
        // R7: misaligned traps here, not in the hardware-alignment variant
        apply(3'd4, 32'h0000_6000, 6'd0, 32'h0, 32'h0000_0003, 1'b0, 1'b0, 4'd0);
        chk(!h_seen, "R7", "hw-align pulse", 64'(h_seen), 64'd0);
        chk(h_cause == h_cause_before, "R7", "hw-align excause", 64'(h_cause), 64'(h_cause_before));
        // R8: debug blocked at and above level, taken below
        apply(3'd5, 32'h0000_7000, 6'd2, 32'h0, 32'h0, 1'b0, 1'b0, 4'd6);
        apply(3'd5, 32'h0000_7100, 6'd2, 32'h0, 32'h0, 1'b0, 1'b1, 4'd9);
        // R9: debug taken at level 5
        apply(3'd5, 32'h0000_7200, 6'd33, 32'h0, 32'h0, 1'b1, 1'b0, 4'd5);
        // R11: unused kinds
        apply(3'd6, 32'h0000_8000, 6'd10, 32'h1, 32'h2, 1'b0, 1'b0, 4'd0);
        apply(3'd7, 32'h0000_8100, 6'd11, 32'h1, 32'h2, 1'b0, 1'b1, 4'd0);

        // R10: request presented in the pulse cycle is ignored
        @(negedge clk);
        req_kind = 3'd0; req_pc = 32'h0000_9000; req_cause = 6'd21;
        ps_in_um = 1'b0; ps_in_excm = 1'b0; ps_in_intlevel = 4'd0;
        model(3'd0);
        req_valid = 1'b1;
        @(negedge clk);
        chk(!req_ready, "R10", "ready during pulse", 64'(req_ready), 64'd0);
        compare("R10");
        req_pc = 32'h0000_9999; req_cause = 6'd22;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!vec_valid, "R10", "second pulse", 64'(vec_valid), 64'd0);
        chk(excause == 6'd21 && epc1 == 32'h0000_9000, "R10", "ignored update",
            64'(excause), 64'd21);
        @(negedge clk);

        // random mix
        for (int i = 0; i < 300; i++) begin
            apply(3'($urandom_range(0, 7)), $urandom, 6'($urandom_range(0, 63)),
                  $urandom, $urandom, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  4'($urandom_range(0, 15)));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule